// File: doc/BRIEF.md
# Automatic Level Control Loop

This block keeps a recording level steady. It reads signed PCM samples from the converter and steps a 6-bit input gain code up or down. The samples arrive with a one-cycle strobe. The block groups every `FRAME_SMP` samples into a frame and measures the frame's peak magnitude. It compares that peak with a programmable target. A frame above the target counts toward an attack step, which lowers the gain by one code. A frame below the target counts first toward a hold time and then toward a decay step, which raises the gain by one code. The lengths of all three timers come from programmable codes and are measured in frames.

A noise gate can be switched on. When it is on, frames quieter than the gate threshold cannot raise the gain. This stops background hiss from being pumped up during silence. While the loop is disabled, software sets the gain directly with a write strobe. While the loop is enabled, that write path is ignored.

Gain code 0 is -17.25 dB and code 63 is +30 dB, with 0.75 dB per code. The reset value is code 23, which is 0 dB.

Top module: `alc_loop`

## Requirements
- R1: After reset, `gain_code` is 23. Code 0 means -17.25 dB, code 63 means +30 dB, and each code step is 0.75 dB.
- R2: While `loop_en` is 0, a cycle with `man_wr` high loads `man_gain` into `gain_code` at the next clock edge.
- R3: While `loop_en` is 1, `man_wr` and `man_gain` have no effect on `gain_code`.
- R4: The frame level is the largest absolute sample value among the `FRAME_SMP` strobed samples of a frame. The most negative sample value counts as the largest positive magnitude. A level exactly equal to `tgt_lvl` is neither loud nor quiet.
- R5: A frame with level above `tgt_lvl` is a loud frame. After `ATK_BASE << atk_code` consecutive loud frames, the gain code falls by one.
- R6: Attack codes of 10 and above all act as code 10.
- R7: Once frames fall below `tgt_lvl`, the first `hold_len` quiet frames change nothing. `hold_len` is 0 for `hold_code` 0, and `HOLD_BASE << (hold_code-1)` otherwise. A loud frame or an in-band frame restarts the hold.
- R8: After the hold, every `DCY_BASE << min(dcy_code,10)` quiet frames raise the gain code by one.
- R9: The gain code stops at 0 and at 63 and never wraps.
- R10: With `gate_en` set, a frame whose level is below `gate_lvl` never raises the gain. Such a frame also discards any partial decay count; the hold progress is kept.
- R11: While the loop is enabled, `gain_code` changes only at the clock edge that completes a frame, and by at most one code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| smp_in | input | SMP_W | Signed PCM sample |
| loop_en | input | 1 | 1 = automatic control active |
| man_wr | input | 1 | Manual gain write strobe |
| man_gain | input | GAIN_W | Manual gain code |
| tgt_lvl | input | SMP_W-1 | Target peak magnitude |
| gate_en | input | 1 | Noise gate enable |
| gate_lvl | input | SMP_W-1 | Noise gate threshold magnitude |
| atk_code | input | 4 | Attack time code |
| dcy_code | input | 4 | Decay time code |
| hold_code | input | 4 | Hold time code |
| gain_code | output | GAIN_W | Applied gain code |

## Verification
The assertions check four properties on every cycle:
- the gain moves by at most one code, and only on frame-completing edges;
- the gain never wraps at either end;
- loud frames and gated frames never raise the gain;
- disabled-mode writes load the written code.

Only the directed scenarios can show the rest:
- the exact number of frames before an attack, hold or decay step;
- the cap on attack codes;
- the peak measurement, including the most negative sample;
- that a gated frame discards partial decay progress.

// File: rtl/alc_loop.sv
module alc_loop #(
  parameter int SMP_W     = 16,
  parameter int GAIN_W    = 6,
  parameter int GAIN_RST  = 23,
  parameter int FRAME_SMP = 48,
  parameter int ATK_BASE  = 6,
  parameter int DCY_BASE  = 24,
  parameter int HOLD_BASE = 2,
  parameter int CODE_CAP  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [SMP_W-1:0]  smp_in,
  input  logic              loop_en,
  input  logic              man_wr,
  input  logic [GAIN_W-1:0] man_gain,
  input  logic [SMP_W-2:0]  tgt_lvl,
  input  logic              gate_en,
  input  logic [SMP_W-2:0]  gate_lvl,
  input  logic [3:0]        atk_code,
  input  logic [3:0]        dcy_code,
  input  logic [3:0]        hold_code,
  output logic [GAIN_W-1:0] gain_code
);
  localparam int MAG_W = SMP_W - 1;
  localparam int FC_W  = $clog2(FRAME_SMP + 1);
  localparam int CNT_W = $clog2(ATK_BASE + DCY_BASE + HOLD_BASE + 1) + 16;
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

  logic [FC_W-1:0]  fcnt;
  logic [MAG_W-1:0] peak, mag, level;
  logic [SMP_W-1:0] neg;
  logic [CNT_W-1:0] atk_cnt, dcy_cnt, hold_cnt, atk_len, dcy_len, hold_len;
  logic [3:0]       atk_sh, dcy_sh;
  logic             frame_end, loud, quiet, gated;

  assign neg   = -smp_in;
  assign mag   = !smp_in[SMP_W-1] ? smp_in[MAG_W-1:0] :
                 neg[SMP_W-1]     ? {MAG_W{1'b1}} : neg[MAG_W-1:0];
  assign level = (mag > peak) ? mag : peak;

  assign frame_end = loop_en && smp_stb && (fcnt == FC_W'(FRAME_SMP - 1));
  assign loud      = level > tgt_lvl;
  assign quiet     = level < tgt_lvl;
  assign gated     = gate_en && (level < gate_lvl);

  assign atk_sh   = (atk_code > 4'(CODE_CAP)) ? 4'(CODE_CAP) : atk_code;
  assign dcy_sh   = (dcy_code > 4'(CODE_CAP)) ? 4'(CODE_CAP) : dcy_code;
  assign atk_len  = CNT_W'(ATK_BASE) << atk_sh;
  assign dcy_len  = CNT_W'(DCY_BASE) << dcy_sh;
  assign hold_len = (hold_code == 4'd0) ? '0 : (CNT_W'(HOLD_BASE) << (hold_code - 4'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt      <= '0;
      peak      <= '0;
      atk_cnt   <= '0;
      dcy_cnt   <= '0;
      hold_cnt  <= '0;
      gain_code <= GAIN_W'(GAIN_RST);
    end else if (!loop_en) begin
      fcnt     <= '0;
      peak     <= '0;
      atk_cnt  <= '0;
      dcy_cnt  <= '0;
      hold_cnt <= '0;
      if (man_wr) gain_code <= man_gain;
    end else if (smp_stb) begin
      if (!frame_end) begin
        fcnt <= fcnt + FC_W'(1);
        peak <= level;
      end else begin
        fcnt <= '0;
        peak <= '0;
        if (loud) begin
          hold_cnt <= '0;
          dcy_cnt  <= '0;
          if (atk_cnt >= atk_len - CNT_W'(1)) begin
            atk_cnt <= '0;
            if (gain_code != '0) gain_code <= gain_code - GAIN_W'(1);
          end else begin
            atk_cnt <= atk_cnt + CNT_W'(1);
          end
        end else if (gated) begin
          atk_cnt <= '0;
          dcy_cnt <= '0;
        end else if (quiet) begin
          atk_cnt <= '0;
          if (hold_cnt < hold_len) begin
            hold_cnt <= hold_cnt + CNT_W'(1);
          end else if (dcy_cnt >= dcy_len - CNT_W'(1)) begin
            dcy_cnt <= '0;
            if (gain_code != GAIN_MAX) gain_code <= gain_code + GAIN_W'(1);
          end else begin
            dcy_cnt <= dcy_cnt + CNT_W'(1);
          end
        end else begin
          atk_cnt  <= '0;
          dcy_cnt  <= '0;
          hold_cnt <= '0;
        end
      end
    end
  end

  a_r2_manual_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && man_wr) |=> (gain_code == $past(man_gain)));

  a_r11_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !frame_end) |=> $stable(gain_code));

  a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> (gain_code == $past(gain_code) ||
                 gain_code == $past(gain_code) + GAIN_W'(1) ||
                 gain_code == $past(gain_code) - GAIN_W'(1)));

  a_r9_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && gain_code == '0) |=> (gain_code != GAIN_MAX));

  a_r9_no_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && gain_code == GAIN_MAX) |=> (gain_code != '0));

  a_r5_loud_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && loud) |=> (gain_code <= $past(gain_code)));

  a_r10_gate_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && gated && !loud) |=> (gain_code == $past(gain_code)));
endmodule

// File: tb/test_alc_loop.sv
module test_alc_loop;
  localparam int SMP_W = 16;
  localparam int GAIN_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic [SMP_W-1:0] smp_in = '0;
  logic loop_en = 1'b0;
  logic man_wr = 1'b0;
  logic [GAIN_W-1:0] man_gain = '0;
  logic [SMP_W-2:0] tgt_lvl = 15'd1000;
  logic gate_en = 1'b0;
  logic [SMP_W-2:0] gate_lvl = 15'd200;
  logic [3:0] atk_code = 4'd0;
  logic [3:0] dcy_code = 4'd0;
  logic [3:0] hold_code = 4'd2;
  logic [GAIN_W-1:0] gain_code;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  alc_loop #(.SMP_W(SMP_W), .GAIN_W(GAIN_W), .GAIN_RST(23), .FRAME_SMP(2),
             .ATK_BASE(1), .DCY_BASE(2), .HOLD_BASE(1), .CODE_CAP(10)) i_alc_loop (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
    .loop_en(loop_en), .man_wr(man_wr), .man_gain(man_gain), .tgt_lvl(tgt_lvl),
    .gate_en(gate_en), .gate_lvl(gate_lvl), .atk_code(atk_code),
    .dcy_code(dcy_code), .hold_code(hold_code), .gain_code(gain_code));

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(gain_code) != exp) begin
      fails++;
      $display("FAIL %s: gain_code=%0d expected %0d", req, gain_code, exp);
    end
  endtask

  task automatic sample(input int v);
    @(negedge clk);
    smp_stb = 1'b1;
    smp_in = SMP_W'(v);
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic frames(input int n, input int a, input int b);
    for (int i = 0; i < n; i++) begin
      sample(a);
      sample(b);
    end
  endtask

  task automatic set_gain(input int v);
    @(negedge clk);
    loop_en = 1'b0;
    man_wr = 1'b1;
    man_gain = GAIN_W'(v);
    @(negedge clk);
    man_wr = 1'b0;
    loop_en = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 reset code", 23);
  endtask

  task automatic t_manual;
    @(negedge clk);
    loop_en = 1'b0;
    man_wr = 1'b1;
    man_gain = 6'd40;
    @(negedge clk);
    man_wr = 1'b0;
    check("R2 manual write", 40);
    loop_en = 1'b1;
    man_wr = 1'b1;
    man_gain = 6'd10;
    @(negedge clk);
    man_wr = 1'b0;
    @(negedge clk);
    check("R3 write ignored", 40);
  endtask

  task automatic t_attack;
    atk_code = 4'd0;
    set_gain(40);
    sample(2000);
    check("R11 mid-frame", 40);
    sample(0);
    check("R5 first attack", 39);
    frames(3, 2000, 0);
    check("R5 attack ramp", 36);
    atk_code = 4'd2;
    frames(3, 2000, 0);
    check("R5 attack code2 early", 36);
    frames(1, 2000, 0);
    check("R5 attack code2 step", 35);
  endtask

  task automatic t_attack_cap;
    atk_code = 4'd12;
    set_gain(35);
    frames(1023, 2000, 0);
    check("R6 capped attack early", 35);
    frames(1, 2000, 0);
    check("R6 capped attack step", 34);
    atk_code = 4'd0;
  endtask

  task automatic t_peak;
    set_gain(30);
    frames(1, 1000, 1000);
    check("R4 equal level", 30);
    frames(1, 500, 1500);
    check("R4 peak second sample", 29);
    frames(1, -32768, 0);
    check("R4 most negative", 28);
    frames(1, -1001, 0);
    check("R4 negative loud", 27);
    frames(1, -1000, 999);
    check("R4 negative at target", 27);
  endtask

  task automatic t_decay;
    hold_code = 4'd2;
    dcy_code = 4'd0;
    set_gain(20);
    frames(3, 100, -100);
    check("R7 hold then partial", 20);
    frames(1, 100, -100);
    check("R8 first decay", 21);
    frames(1, 100, -100);
    check("R8 between steps", 21);
    frames(1, 100, -100);
    check("R8 second decay", 22);
    dcy_code = 4'd1;
    frames(3, 100, 0);
    check("R8 code1 early", 22);
    frames(1, 100, 0);
    check("R8 code1 step", 23);
    dcy_code = 4'd0;
    hold_code = 4'd0;
    set_gain(20);
    frames(1, 100, 0);
    check("R7 no hold partial", 20);
    frames(1, 100, 0);
    check("R7 no hold step", 21);
  endtask

  task automatic t_limits;
    hold_code = 4'd0;
    dcy_code = 4'd0;
    set_gain(62);
    frames(2, 100, 0);
    check("R9 reach top", 63);
    frames(6, 100, 0);
    check("R9 stay top", 63);
    set_gain(1);
    frames(1, 5000, 0);
    check("R9 reach bottom", 0);
    frames(4, 5000, 0);
    check("R9 stay bottom", 0);
  endtask

  task automatic t_gate;
    hold_code = 4'd2;
    dcy_code = 4'd0;
    gate_en = 1'b1;
    gate_lvl = 15'd200;
    set_gain(20);
    frames(10, 100, 0);
    check("R10 gated frozen", 20);
    frames(3, 500, 0);
    check("R10 partial decay", 20);
    frames(1, 100, 0);
    check("R10 gated frame", 20);
    frames(1, 500, 0);
    check("R10 decay restarted", 20);
    frames(1, 500, 0);
    check("R10 decay after gate", 21);
    gate_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_manual;
    t_attack;
    t_attack_cap;
    t_peak;
    t_decay;
    t_limits;
    t_gate;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule